// File: doc/BRIEF.md
# Cache Controller with Selectable Write Policies

This block sits between a processor port that moves one word per request and a memory port that moves one whole block per transaction. It holds a small cache, either direct-mapped or two-way set-associative, with a tag store (valid, tag, dirty and one least-recently-used bit per set) and a data store of whole blocks. Reads that hit return data from the cache. Reads that miss fetch the whole block, evicting a victim line first if needed, and then finish from the cache.

Two static configuration pins choose the write behaviour independently. `cfg_write_back` selects between writing a hit straight through to memory and marking the line dirty. `cfg_write_alloc` selects between fetching the block on a write miss and sending the word to memory alone. The pins are sampled when a request is accepted. The processor holds its request until a one-cycle ready pulse, so every miss, eviction or memory write shows up as stall cycles.

The controller is a six-state machine. **IDLE** accepts a request (IDLE→LOOKUP). **LOOKUP** checks the tags:
- read hit or write-back write hit: LOOKUP→RESP
- write-through write hit, or a write miss without allocation: LOOKUP→MEMWR
- allocating miss with a dirty victim: LOOKUP→EVICT
- allocating miss with a clean or empty victim: LOOKUP→FILL

**EVICT** writes the victim block and moves to FILL on acknowledge (EVICT→FILL). **FILL** reads the block, installs it on acknowledge and returns to LOOKUP (FILL→LOOKUP), where the access now hits. **MEMWR** writes one masked word and moves to RESP on acknowledge (MEMWR→RESP). **RESP** pulses ready and returns to IDLE (RESP→IDLE).

Top module: `cache_ctl`

## Requirements
- R1: A read hit returns the stored word with `cpu_ready` and issues no memory transaction.
- R2: A read miss issues one block read at block address `cpu_addr >> OFF_W`, installs the block and returns the requested word.
- R3: A word address splits, from the top, into tag, set index and word offset (the low OFF_W bits). The set is the block number modulo SETS.
- R4: With `cfg_write_back`=0, a write hit updates the cached word and issues one memory write whose mask has only bit `offset` set, with the word at bits `offset*DATA_W`.
- R5: With `cfg_write_back`=1, a write hit issues no memory transaction and marks the line dirty. The new value reaches memory only when the line is evicted.
- R6: With `cfg_write_alloc`=1, a write miss fetches the block (after any eviction) and then applies the write as a hit under the current hit policy.
- R7: With `cfg_write_alloc`=0, a write miss issues a single masked word write and leaves the cache unchanged, so a later read of that address misses.
- R8: The victim is the lowest-numbered invalid way; if none is invalid, it is the way named by the set's LRU bit. Every hit and every fill sets that bit to the other way.
- R9: A dirty victim is written back as a full block (all mask bits set) before the fill. A clean victim causes no write.
- R10: `cpu_ready` is a one-cycle pulse. At most one memory transaction is outstanding, and `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`.
- R11: After reset all lines are invalid and `cpu_ready` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_write_back | input | 1 | 1: write hits mark the line dirty; 0: write hits go to memory |
| cfg_write_alloc | input | 1 | 1: write misses fetch the block; 0: write misses go to memory only |
| cpu_req | input | 1 | Request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for a write |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ready` on reads |
| cpu_ready | output | 1 | Completion pulse |
| mem_req | output | 1 | Memory transaction request, held until `mem_ack` |
| mem_we | output | 1 | 1 for a block or word write |
| mem_addr | output | ADDR_W-OFF_W | Block address |
| mem_wmask | output | WPB | Per-word write enable |
| mem_wdata | output | WPB*DATA_W | Write block |
| mem_rdata | input | WPB*DATA_W | Read block, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the memory transaction |

## Verification
The bench aims at conflict sequences within one set. These show whether the LRU bit is updated on hits and fills. A wrong update would evict the most recently used line, and that shows up as an unexpected block address in the memory trace.

It also reads a word back after its dirty line has been evicted. A controller that dropped the dirty bit, or fetched before writing back, would return stale data.

Each hit and miss policy combination is checked against its exact list of memory transactions. A write-through hit that stayed silent, or a non-allocating miss that installed the line, appears as a missing or extra entry, or as a later hit that ought to be a miss.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL,
        ST_MEMWR,
        ST_RESP
    } cc_state_e;
endpackage

// File: rtl/cache_ctl_tags.sv
module cache_ctl_tags #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 6,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] vict_way,
    output logic             vict_dirty,
    output logic [TAG_W-1:0] vict_tag,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    input  logic             mark_dirty,
    input  logic             fill_en,
    input  logic [WAY_W-1:0] fill_way
);
    logic [SETS-1:0]  valid_q [WAYS];
    logic [SETS-1:0]  dirty_q [WAYS];
    logic [TAG_W-1:0] tag_q   [WAYS][SETS];
    logic [SETS-1:0]  lru_q;
    logic [WAYS-1:0]  hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[w][idx] && (tag_q[w][idx] == tag);

        // a dirty line is always a valid one
        a_r5_dirty_valid: assert property (@(posedge clk) disable iff (!rst_n)
            dirty_q[w][idx] |-> valid_q[w][idx]);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    if (WAYS == 2) begin : g_two_way
        always_comb begin
            if (!valid_q[0][idx])      vict_way = 1'b0;
            else if (!valid_q[1][idx]) vict_way = 1'b1;
            else                       vict_way = lru_q[idx];
        end
    end else begin : g_one_way
        assign vict_way = '0;
    end

    assign vict_dirty = dirty_q[vict_way][idx];
    assign vict_tag   = tag_q[vict_way][idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                valid_q[w] <= '0;
                dirty_q[w] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[fill_way][idx] <= 1'b1;
                dirty_q[fill_way][idx] <= 1'b0;
            end
            if (mark_dirty) dirty_q[touch_way][idx] <= 1'b1;
            if (touch_en)   lru_q[idx] <= ~touch_way[0];
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_way][idx] <= tag;
    end

    a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/cache_ctl_data.sv
module cache_ctl_data #(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int WPB    = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WPB),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int BLK_W = WPB * DATA_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WAY_W-1:0]  rd_way,
    output logic [BLK_W-1:0]  rd_blk,
    input  logic              word_we,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              blk_we,
    input  logic [BLK_W-1:0]  wr_blk
);
    logic [BLK_W-1:0] line_q [WAYS][SETS];

    assign rd_blk = line_q[rd_way][idx];

    always_ff @(posedge clk) begin
        if (blk_we) begin
            line_q[wr_way][idx] <= wr_blk;
        end else if (word_we) begin
            line_q[wr_way][idx][wr_off*DATA_W +: DATA_W] <= wr_word;
        end
    end
endmodule

// File: rtl/cache_ctl.sv
module cache_ctl
    import cache_ctl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int WPB    = 4,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    localparam int OFF_W   = $clog2(WPB),
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
    localparam int BADDR_W = ADDR_W - OFF_W,
    localparam int BLK_W   = WPB * DATA_W,
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_write_back,
    input  logic               cfg_write_alloc,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_ready,
    output logic               mem_req,
    output logic               mem_we,
    output logic [BADDR_W-1:0] mem_addr,
    output logic [WPB-1:0]     mem_wmask,
    output logic [BLK_W-1:0]   mem_wdata,
    input  logic [BLK_W-1:0]   mem_rdata,
    input  logic               mem_ack
);
    cc_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic              we_q, wb_q, wa_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [WAY_W-1:0]  vict_q;
    logic [TAG_W-1:0]  vtag_q;

    logic [OFF_W-1:0]  off;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    assign off = addr_q[OFF_W-1:0];
    assign idx = addr_q[OFF_W +: IDX_W];
    assign tag = addr_q[ADDR_W-1 -: TAG_W];

    logic             tag_hit, vict_dirty;
    logic [WAY_W-1:0] hit_way, vict_way;
    logic [TAG_W-1:0] vict_tag;
    logic             touch_en, mark_dirty, fill_en, word_we;
    logic [WAY_W-1:0] touch_way, rd_way;
    logic [BLK_W-1:0] rd_blk;

    cache_ctl_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) tags_i (
        .clk(clk), .rst_n(rst_n), .idx(idx), .tag(tag),
        .hit(tag_hit), .hit_way(hit_way),
        .vict_way(vict_way), .vict_dirty(vict_dirty), .vict_tag(vict_tag),
        .touch_en(touch_en), .touch_way(touch_way), .mark_dirty(mark_dirty),
        .fill_en(fill_en), .fill_way(vict_q)
    );

    cache_ctl_data #(.SETS(SETS), .WAYS(WAYS), .WPB(WPB), .DATA_W(DATA_W)) data_i (
        .clk(clk), .idx(idx), .rd_way(rd_way), .rd_blk(rd_blk),
        .word_we(word_we), .wr_way(touch_way), .wr_off(off), .wr_word(wdata_q),
        .blk_we(fill_en), .wr_blk(mem_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cpu_req) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (tag_hit)               state_d = (we_q && !wb_q) ? ST_MEMWR : ST_RESP;
                else if (we_q && !wa_q)    state_d = ST_MEMWR;
                else if (vict_dirty)       state_d = ST_EVICT;
                else                       state_d = ST_FILL;
            end
            ST_EVICT:  if (mem_ack) state_d = ST_FILL;
            ST_FILL:   if (mem_ack) state_d = ST_LOOKUP;
            ST_MEMWR:  if (mem_ack) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and store controls
    always_comb begin
        touch_en   = 1'b0;
        mark_dirty = 1'b0;
        fill_en    = 1'b0;
        word_we    = 1'b0;
        touch_way  = hit_way;
        rd_way     = hit_way;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = addr_q[ADDR_W-1:OFF_W];
        mem_wmask  = WPB'(1) << off;
        mem_wdata  = {WPB{wdata_q}};
        cpu_ready  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOOKUP: begin
                touch_en   = tag_hit;
                word_we    = tag_hit && we_q;
                mark_dirty = tag_hit && we_q && wb_q;
            end
            ST_EVICT: begin
                rd_way    = vict_q;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {vtag_q, idx};
                mem_wmask = '1;
                mem_wdata = rd_blk;
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                touch_way = vict_q;
                fill_en   = mem_ack;
                touch_en  = mem_ack;
            end
            ST_MEMWR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_RESP:  cpu_ready = 1'b1;
            default: ;
        endcase
    end

    assign cpu_rdata = rdata_q;

    // request capture and miss bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wb_q    <= 1'b0;
            wa_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            vict_q  <= '0;
            vtag_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && cpu_req) begin
                addr_q  <= cpu_addr;
                we_q    <= cpu_we;
                wdata_q <= cpu_wdata;
                wb_q    <= cfg_write_back;
                wa_q    <= cfg_write_alloc;
            end
            if (state_q == ST_LOOKUP) begin
                if (tag_hit && !we_q) rdata_q <= rd_blk[off*DATA_W +: DATA_W];
                if (!tag_hit) begin
                    vict_q <= vict_way;
                    vtag_q <= vict_tag;
                end
            end
        end
    end

    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    a_r1_read_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && tag_hit && !we_q) |=> !mem_req);
    a_r4_through_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && tag_hit && we_q && !wb_q) |=> (mem_req && mem_we));
    a_r5_back_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && tag_hit && we_q && wb_q) |=> !mem_req);
    a_r2_fill_installs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_ack) |=> tag_hit);
    a_r9_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT && mem_ack) |=> (mem_req && !mem_we));
endmodule

// File: tb/cache_ctl_tb_top.sv
`timescale 1ns/1ps
module cache_ctl_tb_top;
    localparam int ADDR_W = 10, DATA_W = 32, WPB = 4, SETS = 4, WAYS = 2;
    localparam int OFF_W = 2, IDX_W = 2, BADDR_W = ADDR_W - OFF_W, BLK_W = WPB * DATA_W;
    localparam int NWORDS = 1 << ADDR_W;
    localparam int MEM_LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_write_back = 1'b1, cfg_write_alloc = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic cpu_ready, mem_req, mem_we, mem_ack;
    logic [BADDR_W-1:0] mem_addr;
    logic [WPB-1:0] mem_wmask;
    logic [BLK_W-1:0] mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    cache_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_write_back(cfg_write_back), .cfg_write_alloc(cfg_write_alloc),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wmask(mem_wmask),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0, errors = 0;
    int unsigned mem_arr [NWORDS];
    int unsigned ref_mem [NWORDS];
    int got_q[$];
    int exp_q[$];
    bit waiting = 0, in_access = 0;

    // reference cache state
    bit          m_v [SETS][WAYS];
    bit          m_d [SETS][WAYS];
    int          m_t [SETS][WAYS];
    bit          m_lru [SETS];
    int unsigned m_dat [SETS][WAYS][WPB];

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory responder: transaction codes are kind*65536 + block address
    // kind 1 = full-block write, 2 = block read, 3 = masked word write
    initial begin
        int cnt = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (rst_n && mem_req) begin
                cnt++;
                if (cnt >= MEM_LAT) begin
                    if (mem_we) begin
                        for (int w = 0; w < WPB; w++)
                            if (mem_wmask[w]) mem_arr[int'(mem_addr)*WPB + w] = mem_wdata[w*DATA_W +: DATA_W];
                        got_q.push_back(((mem_wmask == '1) ? 1 : 3) * 65536 + int'(mem_addr));
                    end else begin
                        for (int w = 0; w < WPB; w++)
                            mem_rdata[w*DATA_W +: DATA_W] = mem_arr[int'(mem_addr)*WPB + w];
                        got_q.push_back(2 * 65536 + int'(mem_addr));
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    // per-clock monitor (R10): no ready or memory activity outside an access, ready one cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                check(!(cpu_ready && !waiting), "R10", "ready outside wait", cpu_ready, 0);
                check(!(mem_req && !in_access), "R10", "mem_req outside access", mem_req, 0);
            end
        end
    end

    // reference model of one access; fills exp_q and returns expected read data
    task automatic model(input int addr, input bit we, input int unsigned wd, input bit wb, input bit wa,
                         output int unsigned rd);
        int off = addr % WPB;
        int blk = addr / WPB;
        int set = blk % SETS;
        int tg  = blk / SETS;
        int way = -1;
        rd = 0;
        for (int w = 0; w < WAYS; w++) if (m_v[set][w] && m_t[set][w] == tg) way = w;
        if (way < 0) begin
            if (we && !wa) begin
                exp_q.push_back(3 * 65536 + blk);
                ref_mem[addr] = wd;
                return;
            end
            if (!m_v[set][0]) way = 0;
            else if (!m_v[set][1]) way = 1;
            else way = int'(m_lru[set]);
            if (m_v[set][way] && m_d[set][way]) begin
                int vb = m_t[set][way] * SETS + set;
                exp_q.push_back(1 * 65536 + vb);
                for (int k = 0; k < WPB; k++) ref_mem[vb*WPB + k] = m_dat[set][way][k];
            end
            exp_q.push_back(2 * 65536 + blk);
            for (int k = 0; k < WPB; k++) m_dat[set][way][k] = ref_mem[blk*WPB + k];
            m_v[set][way] = 1; m_d[set][way] = 0; m_t[set][way] = tg;
            m_lru[set] = (way == 0);
        end
        m_lru[set] = (way == 0);
        if (!we) begin
            rd = m_dat[set][way][off];
        end else begin
            m_dat[set][way][off] = wd;
            if (wb) m_d[set][way] = 1;
            else begin
                exp_q.push_back(3 * 65536 + blk);
                ref_mem[addr] = wd;
            end
        end
    endtask

    task automatic access(input string req, input int addr, input bit we, input int unsigned wd,
                          input bit wb, input bit wa);
        int unsigned exp_rd;
        bit seen = 0;
        exp_q.delete();
        got_q.delete();
        model(addr, we, wd, wb, wa, exp_rd);
        @(negedge clk);
        in_access = 1; waiting = 1;
        cfg_write_back = wb; cfg_write_alloc = wa;
        cpu_req = 1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = wd;
        for (int c = 0; c < 200; c++) begin
            @(posedge clk);
            #1;
            if (cpu_ready) begin seen = 1; break; end
        end
        waiting = 0;
        check(seen, req, "ready timeout", 0, 1);
        if (seen && !we) check(cpu_rdata == exp_rd, req, "read data", cpu_rdata, exp_rd);
        check(got_q.size() == exp_q.size(), req, "memory transaction count", got_q.size(), exp_q.size());
        if (got_q.size() == exp_q.size())
            for (int i = 0; i < exp_q.size(); i++)
                check(got_q[i] == exp_q[i], req, "memory transaction", got_q[i], exp_q[i]);
        if (we) check(mem_arr[addr] == ref_mem[addr], req, "memory word after write", mem_arr[addr], ref_mem[addr]);
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
        @(negedge clk);
        in_access = 0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        for (int i = 0; i < NWORDS; i++) begin
            mem_arr[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
            ref_mem[i] = mem_arr[i];
        end
        for (int s = 0; s < SETS; s++) begin
            m_lru[s] = 0;
            for (int w = 0; w < WAYS; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; m_t[s][w] = 0; end
        end
        repeat (3) @(negedge clk);
        check(cpu_ready == 0, "R11", "ready in reset", cpu_ready, 0);
        check(mem_req == 0, "R11", "mem_req in reset", mem_req, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(cpu_ready == 0 && mem_req == 0, "R11", "idle after reset", {cpu_ready, mem_req}, 0);

        // set 0 conflicts: word 0 (tag 0), 16 (tag 1), 32 (tag 2)
        access("R2", 0, 0, 0, 1, 1);              // cold miss, fill block 0
        access("R1", 1, 0, 0, 1, 1);              // hit
        access("R5", 2, 1, 32'hDEAD_0002, 1, 1);  // write-back hit, silent
        access("R8", 16, 0, 0, 1, 1);             // fills invalid way 1
        access("R1", 0, 0, 0, 1, 1);              // hit way 0, LRU -> way 1
        access("R9", 32, 0, 0, 1, 1);             // clean victim way 1, no write
        access("R9", 16, 0, 0, 1, 1);             // dirty victim way 0 written back first
        access("R5", 2, 0, 0, 1, 1);              // written value returns from memory
        access("R4", 17, 1, 32'hBEEF_0011, 0, 1); // write-through hit
        access("R7", 100, 1, 32'h0000_0100, 1, 0);// no-allocate miss
        access("R7", 100, 0, 0, 1, 1);            // must miss and fill
        access("R6", 200, 1, 32'h0000_0200, 1, 1);// allocate, write-back
        access("R6", 300, 1, 32'h0000_0300, 0, 1);// allocate, write-through
        access("R3", 64, 0, 0, 1, 1);             // block 16 -> set 0

        for (int n = 0; n < 400; n++) begin
            int a;
            bit we, wb, wa;
            seed = seed * 32'd1103515245 + 32'd12345;
            a  = int'((seed >> 8) % 128);
            we = seed[28]; wb = seed[29]; wa = seed[30];
            access("R8", a, we, seed ^ 32'hA5A5_0000, wb, wa);
        end

        begin
            int bad = 0;
            for (int i = 0; i < NWORDS; i++) if (mem_arr[i] != ref_mem[i]) bad++;
            check(bad == 0, "R9", "memory image mismatches", bad, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule